// File: doc/BRIEF.md
# Mixed-width unsigned magnitude comparator

This block compares two unsigned operands whose widths are set separately and returns one result bit. A two-bit mode input chooses the relation: strictly less, less or equal, strictly greater, or greater or equal. The block has no clock, so the result follows the inputs within the same time step.

The comparison runs over the wider of the two widths. Positions that lie above the narrower operand count as zero. A chain of equality terms runs from the top bit downward. A position raises a decision when the two operands first differ there and the difference points the way the mode asks. The result is the OR of all these decisions. In the inclusive modes one more input joins the OR: the term that says every bit matched.

Top module: `mixcmp`

## Requirements
- R1: With rel_mode = 2'b00 the output is 1 exactly when op_a < op_b, both taken as unsigned.
- R2: With rel_mode = 2'b01 the output is 1 exactly when op_a <= op_b.
- R3: With rel_mode = 2'b10 the output is 1 exactly when op_a > op_b.
- R4: With rel_mode = 2'b11 the output is 1 exactly when op_a >= op_b.
- R5: When WA and WB differ, the narrower operand is zero-extended to the wider width before the comparison, whichever side is narrower.
- R6: For equal operands the output is 0 in the two strict modes (2'b00, 2'b10) and 1 in the two inclusive modes (2'b01, 2'b11).
- R7: At most one bit position raises a less-than decision and at most one raises a greater-than decision: the highest differing position. A less-than and a greater-than decision are never both raised.
- R8: The output depends only on the present inputs and settles in the same time step as an input change, with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WA | Left operand, unsigned |
| op_b | input | WB | Right operand, unsigned |
| rel_mode | input | 2 | Relation select: 00 less, 01 less-or-equal, 10 greater, 11 greater-or-equal |
| cmp_out | output | 1 | 1 when op_a stands in the selected relation to op_b |

## Verification
The bench sweeps every operand pair in every mode for the widths 8/8, 8/4 and 4/8. A design that did not zero-extend, or that lost the upper bits, would give wrong answers whenever the wider operand has bits set above the narrower width. Equal operands are the boundary between the strict and inclusive modes. A design that dropped the final all-equal term, or OR-ed it into the strict modes, would flip exactly those cases. Directed vectors place the first difference at the top bit and at the bottom bit. These catch a chain that starts at the wrong end or misses a position, which would let a lower bit overrule a higher one.

// File: rtl/mixcmp.sv
module mixcmp #(
  parameter int WA = 8,
  parameter int WB = 8
) (
  input  logic [WA-1:0] op_a,
  input  logic [WB-1:0] op_b,
  input  logic [1:0]    rel_mode,
  output logic          cmp_out
);
  localparam int WN = (WA > WB) ? WA : WB;

  logic [WN-1:0] ax, bx;
  logic [WN:0]   eq_above;
  logic [WN-1:0] lt_dec, gt_dec, sel_dec;

  for (genvar i = 0; i < WN; i++) begin : g_ext
    if (i < WA) begin : g_a
      assign ax[i] = op_a[i];
    end else begin : g_az
      assign ax[i] = 1'b0;
    end
    if (i < WB) begin : g_b
      assign bx[i] = op_b[i];
    end else begin : g_bz
      assign bx[i] = 1'b0;
    end
  end

  assign eq_above[WN] = 1'b1;

  for (genvar i = WN - 1; i >= 0; i--) begin : g_scan
    assign eq_above[i] = eq_above[i+1] & ~(ax[i] ^ bx[i]);
    assign lt_dec[i]   = ~ax[i] &  bx[i] & eq_above[i+1];
    assign gt_dec[i]   =  ax[i] & ~bx[i] & eq_above[i+1];
  end

  assign sel_dec = rel_mode[1] ? gt_dec : lt_dec;
  assign cmp_out = |{rel_mode[0] & eq_above[0], sel_dec};
endmodule

// File: rtl/mixcmp_chk.sv
module mixcmp_chk #(
  parameter int WN = 8
) (
  input logic [WN:0]   eq_above,
  input logic [WN-1:0] lt_dec,
  input logic [WN-1:0] gt_dec,
  input logic [1:0]    rel_mode,
  input logic          cmp_out
);
  always_comb begin
    if (!$isunknown({eq_above, lt_dec, gt_dec, rel_mode, cmp_out})) begin
      assert_single_lt_R7: assert ($onehot0(lt_dec));
      assert_single_gt_R7: assert ($onehot0(gt_dec));
      assert_one_outcome_R7: assert ($countones({|lt_dec, |gt_dec, eq_above[0]}) == 1);
      if (eq_above[0]) begin
        assert_equal_follows_mode_R6: assert (cmp_out == rel_mode[0]);
      end
      if (|lt_dec) begin
        assert_less_result_R1: assert (cmp_out == !rel_mode[1]);
      end
      if (|gt_dec) begin
        assert_greater_result_R3: assert (cmp_out == rel_mode[1]);
      end
    end
  end
endmodule

bind mixcmp mixcmp_chk #(.WN(WN)) u_chk (
  .eq_above(eq_above),
  .lt_dec(lt_dec),
  .gt_dec(gt_dec),
  .rel_mode(rel_mode),
  .cmp_out(cmp_out)
);

// File: tb/mixcmp_bench.sv
module mixcmp_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] a8, b8;
  logic [3:0] a4, b4;
  logic [1:0] mode;
  logic out88, out84, out48;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  mixcmp #(.WA(8), .WB(8)) u_mixcmp (.op_a(a8), .op_b(b8), .rel_mode(mode), .cmp_out(out88));
  mixcmp #(.WA(8), .WB(4)) u_mixcmp_a8b4 (.op_a(a8), .op_b(b4), .rel_mode(mode), .cmp_out(out84));
  mixcmp #(.WA(4), .WB(8)) u_mixcmp_a4b8 (.op_a(a4), .op_b(b8), .rel_mode(mode), .cmp_out(out48));

  typedef struct packed {
    logic [1:0] m;
    logic [7:0] a;
    logic [7:0] b;
    logic       e;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{2'b00, 8'h00, 8'h00, 1'b0},  // R6
    '{2'b01, 8'h00, 8'h00, 1'b1},  // R6
    '{2'b10, 8'hFF, 8'hFF, 1'b0},  // R6
    '{2'b11, 8'hFF, 8'hFF, 1'b1},  // R6
    '{2'b00, 8'h7F, 8'h80, 1'b1},  // R1 top bit decides
    '{2'b10, 8'h7F, 8'h80, 1'b0},  // R3
    '{2'b00, 8'hA4, 8'hA5, 1'b1},  // R1 bottom bit decides
    '{2'b01, 8'hA5, 8'hA4, 1'b0},  // R2
    '{2'b10, 8'h80, 8'h7F, 1'b1},  // R3
    '{2'b11, 8'h3C, 8'h3D, 1'b0},  // R4
    '{2'b11, 8'h3D, 8'h3C, 1'b1},  // R4
    '{2'b01, 8'h10, 8'h11, 1'b1},  // R2
    '{2'b00, 8'h55, 8'hAA, 1'b1},  // R1
    '{2'b10, 8'h01, 8'h00, 1'b1}   // R3
  };

  function automatic logic ref_rel(input logic [1:0] m, input logic [7:0] x, input logic [7:0] y);
    case (m)
      2'b00:   return x <  y;
      2'b01:   return x <= y;
      2'b10:   return x >  y;
      default: return x >= y;
    endcase
  endfunction

  function automatic string mode_req(input logic [1:0] m);
    case (m)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      if (failures <= 20)
        $display("FAIL %s mode=%b a8=%h b8=%h a4=%h b4=%h got=%b exp=%b",
                 req, mode, a8, b8, a4, b4, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES && !finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog got=%0d cycles exp=<%0d", cycles, WATCHDOG_CYCLES);
      finish_run();
    end
  end

  initial begin
    a8 = '0; b8 = '0; a4 = '0; b4 = '0; mode = 2'b00;
    #1;
    check("R6", out88, 1'b0);  // idle inputs: equal zeros, strict mode
    check("R6", out84, 1'b0);
    check("R6", out48, 1'b0);

    foreach (VECS[k]) begin
      mode = VECS[k].m; a8 = VECS[k].a; b8 = VECS[k].b;
      #1;
      check((VECS[k].a == VECS[k].b) ? "R6" : mode_req(VECS[k].m), out88, VECS[k].e);
    end

    // R8: output follows an input change with no clock edge in between
    mode = 2'b00; a8 = 8'h20; b8 = 8'h21;
    #1 check("R8", out88, 1'b1);
    b8 = 8'h1F;
    #1 check("R8", out88, 1'b0);

    // R5 directed: bits above the narrow operand must decide the result
    mode = 2'b10; a8 = 8'h10; b4 = 4'hF;
    #1 check("R5", out84, 1'b1);
    mode = 2'b00; a4 = 4'hF; b8 = 8'h10;
    #1 check("R5", out48, 1'b1);

    for (int m = 0; m < 4; m++) begin
      mode = m[1:0];
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          a8 = x[7:0]; b8 = y[7:0];
          a4 = x[3:0]; b4 = y[3:0];
          #1;
          check((x == y) ? "R6" : mode_req(mode), out88, ref_rel(mode, a8, b8));
          if (y < 16)
            check("R5", out84, ref_rel(mode, a8, {4'h0, b4}));
          if (x < 16)
            check("R5", out48, ref_rel(mode, {4'h0, a4}, b8));
        end
      end
    end

    finish_run();
  end
endmodule